// File: doc/BRIEF.md
# Requester ID to Stream ID Mapper

This block sits beside one PCIe controller. It turns the 16-bit requester ID of an inbound transaction into the stream ID that a downstream translation unit consumes. The requester ID carries the bus number in bits 15:8, the device number in bits 7:3 and the function number in bits 2:0. The block holds a table of 32 associative entries. Each entry has a key ID, a per-bit compare mask, a stream ID and an enable bit. Every lookup compares the presented ID against all entries at once.

Software fills the table through a 32-bit register port. Each entry has two words at a stride of 8 bytes. The first word carries the key and the mask, and the second carries the enable bit and the stream ID. A separate register supplies the stream ID that is returned when no entry matches. Each lookup is a single-cycle strobe, and its registered result appears one clock later.

Top module: `rid_sid_mapper`

## Requirements
- R1: The upper word of entry n sits at byte address 0x800 + 8*n and the lower word at 0x804 + 8*n, for n from 0 to 31. Both words read back exactly the 32-bit value last written. Reads are combinational on reg_addr_i.
- R2: After reset, every entry word reads 0, so every entry is disabled. The default register also reads 0, and rsp_valid_o and rsp_hit_o are 0.
- R3: The key ID is upper-word bits 31:16. With a mask of zero, an enabled entry hits only when all 16 requester ID bits are equal to its key. On a hit, rsp_sid_o carries lower-word bits 15:0 of that entry.
- R4: The mask is upper-word bits 15:0. A mask bit of 1 makes the matching ID bit a don't-care, so one entry can cover, for example, every function of a device.
- R5: The enable bit is lower-word bit 31. An entry whose enable bit is 0 never produces a hit, whatever its key and mask.
- R6: When several enabled entries match, the entry with the lowest index wins. rsp_idx_o reports that index.
- R7: On a miss, rsp_hit_o is 0, rsp_sid_o equals bits 15:0 of the default register at byte address 0x7F8, and rsp_idx_o is 0.
- R8: rsp_valid_o is 1 exactly in the cycle after a cycle with req_valid_i high. rsp_hit_o is never 1 while rsp_valid_o is 0.
- R9: A lookup presented in the same cycle as a register write sees the table and the default register as they were before that write.
- R10: A write to an address outside the entry window and the default register changes no state. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address, used for both read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| req_valid_i | input | 1 | Lookup request strobe |
| req_rid_i | input | 16 | Requester ID to translate |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_hit_o | output | 1 | An enabled entry matched |
| rsp_sid_o | output | 16 | Stream ID, or the default value on a miss |
| rsp_idx_o | output | 5 | Index of the winning entry, 0 on a miss |

## Verification
Register reads are combinational, so the bench samples reg_rdata_o about 1 ns after it changes the address. Register writes take effect at the next rising edge. A lookup result is due in the cycle after the strobe. The bench drives req_valid_i for one cycle on a falling edge and samples all four response outputs on the following falling edge, after exactly one rising edge. For the same-cycle case, the bench places the write and the request on the same falling edge. It then expects the old result first and the new result from a second lookup.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 12;
  localparam int RID_W  = 16;
  localparam int EN_BIT = 31;
  localparam logic [ADDR_W-1:0] ENTRY_BASE = 12'h800;
  localparam logic [ADDR_W-1:0] DFLT_ADDR  = 12'h7F8;

  typedef struct packed {
    logic [RID_W-1:0] key;
    logic [RID_W-1:0] mask;
  } upper_t;
endpackage

// File: rtl/rsm_regfile.sv
module rsm_regfile
  import rsm_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  parameter int SID_W     = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [REG_W-1:0]                 wdata_i,
  output logic [REG_W-1:0]                 rdata_o,
  output logic [N_ENTRIES-1:0][REG_W-1:0]  up_o,
  output logic [N_ENTRIES-1:0][REG_W-1:0]  lo_o,
  output logic [SID_W-1:0]                 dflt_o
);
  localparam int IDX_W = $clog2(N_ENTRIES);
  localparam logic [ADDR_W:0] TBL_END = {1'b0, ENTRY_BASE} + (ADDR_W+1)'(8 * N_ENTRIES);

  logic [N_ENTRIES-1:0][REG_W-1:0] up_q, lo_q;
  logic [SID_W-1:0]  dflt_q;
  logic              in_tbl, sel_lo, is_dflt;
  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    in_tbl  = (addr_i >= ENTRY_BASE) && ({1'b0, addr_i} < TBL_END);
    off     = addr_i - ENTRY_BASE;
    idx     = off[IDX_W+2:3];
    sel_lo  = off[2];
    is_dflt = (addr_i == DFLT_ADDR);
  end

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        up_q[g] <= '0;
        lo_q[g] <= '0;
      end else if (wr_i && in_tbl && idx == IDX_W'(g)) begin
        if (sel_lo) lo_q[g] <= wdata_i;
        else        up_q[g] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              dflt_q <= '0;
    else if (wr_i && is_dflt) dflt_q <= wdata_i[SID_W-1:0];
  end

  always_comb begin
    if (in_tbl)       rdata_o = sel_lo ? lo_q[idx] : up_q[idx];
    else if (is_dflt) rdata_o = REG_W'(dflt_q);
    else              rdata_o = '0;
  end

  assign up_o   = up_q;
  assign lo_o   = lo_q;
  assign dflt_o = dflt_q;
endmodule

// File: rtl/rsm_match.sv
module rsm_match
  import rsm_pkg::*;
#(
  parameter int N_ENTRIES = 32
) (
  input  logic [RID_W-1:0]                 rid_i,
  input  logic [N_ENTRIES-1:0][REG_W-1:0]  up_i,
  input  logic [N_ENTRIES-1:0][REG_W-1:0]  lo_i,
  output logic [N_ENTRIES-1:0]             hit_vec_o
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    upper_t u;
    assign u = upper_t'(up_i[g]);
    // mask bit set = don't care
    assign hit_vec_o[g] = lo_i[g][EN_BIT] && (((rid_i ^ u.key) & ~u.mask) == '0);
  end
endmodule

// File: rtl/rsm_prio.sv
module rsm_prio #(
  parameter int N_ENTRIES = 32,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0] hit_vec_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o
);
  always_comb begin
    any_o = |hit_vec_i;
    idx_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/rid_sid_mapper.sv
module rid_sid_mapper
  import rsm_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  parameter int SID_W     = 16,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic               req_valid_i,
  input  logic [RID_W-1:0]   req_rid_i,
  output logic               rsp_valid_o,
  output logic               rsp_hit_o,
  output logic [SID_W-1:0]   rsp_sid_o,
  output logic [IDX_W-1:0]   rsp_idx_o
);
  logic [N_ENTRIES-1:0][REG_W-1:0] up, lo;
  logic [SID_W-1:0]     dflt_sid;
  logic [N_ENTRIES-1:0] hit_vec, en_vec;
  logic                 any_hit;
  logic [IDX_W-1:0]     win_idx;
  logic [SID_W-1:0]     sel_sid;

  rsm_regfile #(.N_ENTRIES(N_ENTRIES), .SID_W(SID_W)) regs_i (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .up_o(up), .lo_o(lo), .dflt_o(dflt_sid)
  );

  rsm_match #(.N_ENTRIES(N_ENTRIES)) match_i (
    .rid_i(req_rid_i), .up_i(up), .lo_i(lo), .hit_vec_o(hit_vec)
  );

  rsm_prio #(.N_ENTRIES(N_ENTRIES)) prio_i (
    .hit_vec_i(hit_vec), .any_o(any_hit), .idx_o(win_idx)
  );

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_en
    assign en_vec[g] = lo[g][EN_BIT];
  end

  assign sel_sid = any_hit ? lo[win_idx][SID_W-1:0] : dflt_sid;

  // lookup reads pre-write table state: storage updates on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_sid_o   <= '0;
      rsp_idx_o   <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= req_valid_i && any_hit;
      if (req_valid_i) begin
        rsp_sid_o <= sel_sid;
        rsp_idx_o <= any_hit ? win_idx : '0;
      end
    end
  end
endmodule

// File: rtl/rsm_checker.sv
module rsm_checker #(
  parameter int N_ENTRIES = 32,
  parameter int SID_W     = 16,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 rsp_valid_o,
  input logic                 rsp_hit_o,
  input logic [SID_W-1:0]     rsp_sid_o,
  input logic [IDX_W-1:0]     rsp_idx_o,
  input logic [N_ENTRIES-1:0] hit_vec,
  input logic [N_ENTRIES-1:0] en_vec,
  input logic [SID_W-1:0]     dflt_sid
);
  logic [N_ENTRIES-1:0] en_d1, hit_d1, below;
  logic [SID_W-1:0]     dflt_d1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d1   <= '0;
      hit_d1  <= '0;
      dflt_d1 <= '0;
    end else begin
      en_d1   <= en_vec;
      hit_d1  <= hit_vec;
      dflt_d1 <= dflt_sid;
    end
  end

  assign below = (N_ENTRIES'(1) << rsp_idx_o) - N_ENTRIES'(1);

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R8
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_hit_o)); // R8
  AST_HIT_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> en_d1[rsp_idx_o]); // R5
  AST_HIT_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> (hit_d1[rsp_idx_o] && ((hit_d1 & below) == '0))); // R6
  AST_MISS_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_sid_o == dflt_d1)); // R7
endmodule

bind rid_sid_mapper rsm_checker #(.N_ENTRIES(N_ENTRIES), .SID_W(SID_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_sid_o(rsp_sid_o),
  .rsp_idx_o(rsp_idx_o), .hit_vec(hit_vec), .en_vec(en_vec), .dflt_sid(dflt_sid)
);

// File: tb/rid_sid_mapper_tb_top.sv
module rid_sid_mapper_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        req_valid_i = 1'b0;
  logic [15:0] req_rid_i = '0;
  logic        rsp_valid_o, rsp_hit_o;
  logic [15:0] rsp_sid_o;
  logic [4:0]  rsp_idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i; // 125 MHz

  rid_sid_mapper dut_i (.*);

  // {rid[37:22], hit[21], sid[20:5], idx[4:0]}
  localparam int NV = 10;
  localparam logic [37:0] VEC [NV] = '{
    {16'h0100, 1'b1, 16'h0011, 5'd0},   // R3 exact
    {16'h0101, 1'b0, 16'h0ABC, 5'd0},   // R3 function differs
    {16'h1100, 1'b0, 16'h0ABC, 5'd0},   // R3 bus bit differs
    {16'h020D, 1'b1, 16'h0022, 5'd1},   // R4 masked function
    {16'h0209, 1'b1, 16'h0022, 5'd1},   // R6 entry1 beats entry2
    {16'h0210, 1'b0, 16'h0ABC, 5'd0},   // R4 unmasked device bit
    {16'h0300, 1'b0, 16'h0ABC, 5'd0},   // R5 disabled entry
    {16'h0500, 1'b1, 16'h0066, 5'd30},  // R6 entry30 beats entry31
    {16'h05AB, 1'b1, 16'h0066, 5'd30},  // R4 masked bus-local bits
    {16'h0000, 1'b0, 16'h0ABC, 5'd0}    // R7 unprogrammed entries
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    reg_addr_i = a;
    #1;
    chk(req, reg_rdata_o, exp);
  endtask

  task automatic lookup(input string req, input logic [15:0] rid,
                        input logic hit, input logic [15:0] sid, input logic [4:0] idx);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_rid_i = rid;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk({req, " valid"}, 32'(rsp_valid_o), 32'd1);
    chk({req, " hit"},   32'(rsp_hit_o),   32'(hit));
    chk({req, " sid"},   32'(rsp_sid_o),   32'(sid));
    chk({req, " idx"},   32'(rsp_idx_o),   32'(idx));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R2 reset state
    chk("R2 rsp_valid", 32'(rsp_valid_o), 32'd0);
    chk("R2 rsp_hit", 32'(rsp_hit_o), 32'd0);
    rd_chk("R2 e0 upper", 12'h800, 32'h0);
    rd_chk("R2 e31 lower", 12'h8FC, 32'h0);
    rd_chk("R2 default", 12'h7F8, 32'h0);
    rst_ni = 1'b1;

    wr(12'h800, 32'h0100_0000); wr(12'h804, 32'h8000_0011);
    wr(12'h808, 32'h0208_0007); wr(12'h80C, 32'h8000_0022);
    wr(12'h810, 32'h0209_0000); wr(12'h814, 32'h8000_0033);
    wr(12'h818, 32'h0300_0000); wr(12'h81C, 32'h0000_0044);
    wr(12'h828, 32'hDEAD_BEEF);
    wr(12'h8F0, 32'h0500_00FF); wr(12'h8F4, 32'h8000_0066);
    wr(12'h8F8, 32'h0500_0000); wr(12'h8FC, 32'h8000_0055);
    wr(12'h7F8, 32'h0000_0ABC);

    // R1 readback
    rd_chk("R1 e1 upper", 12'h808, 32'h0208_0007);
    rd_chk("R1 e1 lower", 12'h80C, 32'h8000_0022);
    rd_chk("R1 e5 upper", 12'h828, 32'hDEAD_BEEF);
    rd_chk("R1 e31 lower", 12'h8FC, 32'h8000_0055);
    rd_chk("R7 default readback", 12'h7F8, 32'h0000_0ABC);

    // R10 out-of-window write ignored
    wr(12'h900, 32'hFFFF_FFFF);
    wr(12'h7F4, 32'hFFFF_FFFF);
    rd_chk("R10 unmapped read", 12'h900, 32'h0);
    rd_chk("R10 e0 upper intact", 12'h800, 32'h0100_0000);
    rd_chk("R10 e31 lower intact", 12'h8FC, 32'h8000_0055);
    rd_chk("R10 default intact", 12'h7F8, 32'h0000_0ABC);

    for (int i = 0; i < NV; i++) begin
      lookup("R3-R7 vector", VEC[i][37:22], VEC[i][21], VEC[i][20:5], VEC[i][4:0]);
    end

    // R8 no response without request
    @(negedge clk_i);
    chk("R8 idle valid", 32'(rsp_valid_o), 32'd0);
    chk("R8 idle hit", 32'(rsp_hit_o), 32'd0);

    // R7 changed default
    wr(12'h7F8, 32'h0000_0123);
    lookup("R7 new default", 16'h0777, 1'b0, 16'h0123, 5'd0);

    // R9 write enable of entry3 in same cycle as lookup
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = 12'h81C; reg_wdata_i = 32'h8000_0044;
    req_valid_i = 1'b1; req_rid_i = 16'h0300;
    @(negedge clk_i);
    reg_wr_i = 1'b0; req_valid_i = 1'b0;
    chk("R9 old hit", 32'(rsp_hit_o), 32'd0);
    chk("R9 old sid", 32'(rsp_sid_o), 32'h0123);
    lookup("R9 new contents", 16'h0300, 1'b1, 16'h0044, 5'd3);

    // R5 disable entry0 again
    wr(12'h804, 32'h0000_0011);
    lookup("R5 disabled e0", 16'h0100, 1'b0, 16'h0123, 5'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule